// File: doc/BRIEF.md
# Three-Channel Interval Timer Waveform Generator

This peripheral holds three independent up-counters, each one driving a pulse-width waveform output. A channel counts from zero up to a programmed interval value and then returns to zero, so the interval sets the waveform period. A programmed match value sets the count at which the output changes level, and this sets the duty cycle. Each channel can divide its count rate by a power of two. Each channel also has a set of status flags and an enable mask, which feed a per-channel interrupt line.

Software reaches every register over a simple single-cycle 32-bit bus. Read data is combinational from the address. Writes take effect at the clock edge on which `wr_en` is high. Register offsets have a stride of 4 bytes per channel, so the three copies of each register sit next to each other. When a channel is disabled it halts at once, in the middle of a period, and drives the inactive level. A changed setting takes effect cleanly when software writes the restart bit.

Top module: `tri_interval_pwm`

## Requirements
- R1: After reset, the counter control register reads 0x61 (bit 0 disable, bit 5 waveform off, bit 6 normal polarity). Clock control reads 0, every count reads 0, and all `wave` and `irq` outputs are low.
- R2: In interval mode (counter control bit 1 = 1), the count goes 0, 1, ..., interval and then returns to 0. With normal polarity and match mode on, `wave` is high while count < match and low otherwise.
- R3: Clock control bit 0 enables the prescaler and bits 4:1 hold N. With the prescaler on, the count advances once every 2^(N+1) clocks, counted from the restart. With it off, the count advances every clock.
- R4: Counter control bit 6 = 0 inverts the waveform relative to R2.
- R5: Counter control bit 5 is an active-low waveform enable. When it is 1, `wave` holds the inactive level (the inverse of bit 6) while the counter keeps running.
- R6: Counter control bit 0 = 1 freezes the count from the edge that writes it, and `wave` drops to the inactive level. Clearing the bit without a restart resumes counting from the frozen value.
- R7: Writing 1 to counter control bit 4 restarts the count and the prescaler from zero. The bit reads back as 0.
- R8: Status bit 0 is set when the interval wrap happens. Reading the status register clears it, and events that occur in the same cycle are kept. `irq[c]` is the OR of status AND interrupt enable (bits 2:0). Writes to status have no effect.
- R9: In free-running mode (bit 1 = 0), the count wraps from 2^W−1 to 0 and sets status bit 2.
- R10: In match mode (counter control bit 3 = 1), status bit 1 is set on the tick where the count becomes equal to the match value.
- R11: The register for channel c is at base + 4c. The bases are clock control 0x00, counter control 0x0C, count 0x18 (read-only), interval 0x24, match 0x30, status 0x54 and interrupt enable 0x60. Channels work independently of each other.
- R12: With match mode off, `wave` stays at the active level for the whole period.
- R13: Clock control bit 5 (clock source) is stored and read back. Bits that are not implemented read as 0, and addresses that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on read) |
| addr | input | AW | Byte address of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| wave | output | 3 | Waveform output per channel |
| irq | output | 3 | Interrupt per channel |

## Verification
The main sweep runs all three channels at once over every interval from 1 to 6 and every match value from 0 to interval+1. This covers the duty cycle at 0, at full, and in between. The channels use different divide rates (1, 2 and 4, then 16) and mixed polarities, so a wrong prescale exponent, a swapped channel stride or a reversed polarity each give a different output. A second pass turns match mode off on one channel to separate the R12 behaviour from a match value above the interval. Separate directed runs hit the cycle-exact freeze and resume, restart, the flag clear-on-read race, and the full 2^W free-running wrap.

// File: rtl/tri_interval_pwm.sv
module tri_interval_pwm #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [2:0]    wave,
  output logic [2:0]    irq
);
  localparam int NCH = 3;
  localparam int STRIDE = 4;
  localparam int PSW = 16;
  localparam int O_CLK = 'h00, O_CTL = 'h0C, O_CNT = 'h18, O_IVL = 'h24;
  localparam int O_MAT = 'h30, O_STS = 'h54, O_IEN = 'h60;
  localparam logic [W-1:0] CMAX = '1;

  logic [NCH-1:0]        dis, imode, restart;
  logic [NCH-1:0][W-1:0] cnt, ival;
  logic [NCH-1:0][31:0]  rdv;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CLK = AW'(O_CLK + STRIDE*i);
    localparam logic [AW-1:0] A_CTL = AW'(O_CTL + STRIDE*i);
    localparam logic [AW-1:0] A_CNT = AW'(O_CNT + STRIDE*i);
    localparam logic [AW-1:0] A_IVL = AW'(O_IVL + STRIDE*i);
    localparam logic [AW-1:0] A_MAT = AW'(O_MAT + STRIDE*i);
    localparam logic [AW-1:0] A_STS = AW'(O_STS + STRIDE*i);
    localparam logic [AW-1:0] A_IEN = AW'(O_IEN + STRIDE*i);

    logic           ps_en, src, r_dis, r_im, mm, wav_n, pol;
    logic [3:0]     ps_n;
    logic [W-1:0]   r_cnt, r_ivl, mval, nxt;
    logic [PSW-1:0] pc, mask;
    logic [2:0]     sts, ien, ev;
    logic           w_clk, w_ctl, w_ivl, w_mat, w_ien, r_sts;
    logic           tick, wrap_i, wrap_o, raw;

    assign w_clk = wr_en && addr == A_CLK;
    assign w_ctl = wr_en && addr == A_CTL;
    assign w_ivl = wr_en && addr == A_IVL;
    assign w_mat = wr_en && addr == A_MAT;
    assign w_ien = wr_en && addr == A_IEN;
    assign r_sts = rd_en && addr == A_STS;
    assign restart[i] = w_ctl && wdata[4];

    assign mask   = PSW'((17'd2 << ps_n) - 17'd1);
    assign tick   = !r_dis && (!ps_en || ((pc & mask) == mask));
    assign wrap_i = r_im && r_cnt == r_ivl;
    assign wrap_o = !wrap_i && r_cnt == CMAX;
    assign nxt    = wrap_i ? '0 : r_cnt + W'(1);
    assign ev     = tick ? {wrap_o, mm && nxt == mval, wrap_i} : 3'b000;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ps_en <= 1'b0; ps_n <= '0; src <= 1'b0;
        r_dis <= 1'b1; r_im <= 1'b0; mm <= 1'b0; wav_n <= 1'b1; pol <= 1'b1;
        r_cnt <= '0; r_ivl <= '0; mval <= '0; pc <= '0; sts <= '0; ien <= '0;
      end else begin
        if (w_clk) begin
          ps_en <= wdata[0];
          ps_n  <= wdata[4:1];
          src   <= wdata[5];
        end
        if (w_ctl) begin
          r_dis <= wdata[0];
          r_im  <= wdata[1];
          mm    <= wdata[3];
          wav_n <= wdata[5];
          pol   <= wdata[6];
        end
        if (w_ivl) r_ivl <= wdata[W-1:0];
        if (w_mat) mval  <= wdata[W-1:0];
        if (w_ien) ien   <= wdata[2:0];
        if (restart[i]) begin
          r_cnt <= '0;
          pc    <= '0;
        end else if (!r_dis) begin
          pc <= pc + PSW'(1);
          if (tick) r_cnt <= nxt;
        end
        sts <= r_sts ? ev : (sts | ev);
      end
    end

    assign raw     = mm ? (r_cnt < mval) : 1'b1;
    assign wave[i] = (!r_dis && !wav_n) ? (pol ? raw : !raw) : !pol;
    assign irq[i]  = |(sts & ien);

    assign dis[i]   = r_dis;
    assign imode[i] = r_im;
    assign cnt[i]   = r_cnt;
    assign ival[i]  = r_ivl;

    always_comb begin
      rdv[i] = '0;
      case (addr)
        A_CLK:   rdv[i] = {26'd0, src, ps_n, ps_en};
        A_CTL:   rdv[i] = {25'd0, pol, wav_n, 1'b0, mm, 1'b0, r_im, r_dis};
        A_CNT:   rdv[i] = 32'(r_cnt);
        A_IVL:   rdv[i] = 32'(r_ivl);
        A_MAT:   rdv[i] = 32'(mval);
        A_STS:   rdv[i] = {29'd0, sts};
        A_IEN:   rdv[i] = {29'd0, ien};
        default: rdv[i] = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) rdata = rdata | rdv[i];
  end
endmodule

// File: rtl/tri_interval_pwm_chk.sv
module tri_interval_pwm_chk #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic [AW-1:0]       addr,
  input logic [31:0]         rdata,
  input logic [2:0]          restart,
  input logic [2:0]          dis,
  input logic [2:0]          imode,
  input logic [2:0][W-1:0]   cnt,
  input logic [2:0][W-1:0]   ival
);
  for (genvar i = 0; i < 3; i++) begin : g_a
    AST_DIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dis[i]) && !$past(restart[i])) |-> $stable(cnt[i])); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart[i]) |-> cnt[i] == '0); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(imode[i]) && imode[i] && $stable(ival[i]) && $past(cnt[i] <= ival[i]))
      |-> cnt[i] <= ival[i]); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(restart[i]) && cnt[i] != $past(cnt[i]))
      |-> (cnt[i] == W'($past(cnt[i]) + 1) || cnt[i] == '0)); // R9
    AST_CTL_RST_READ0: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(12 + 4*i)) |-> !rdata[4]); // R7
  end
endmodule

bind tri_interval_pwm tri_interval_pwm_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .restart(restart), .dis(dis), .imode(imode), .cnt(cnt), .ival(ival)
);

// File: tb/sim_tri_interval_pwm.sv
`timescale 1ns/1ps
module sim_tri_interval_pwm;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  wave, irq;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  tri_interval_pwm u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wave(wave), .irq(irq));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: expired after %0d cycles (expected completion)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = 32'(d);
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = 8'(a);
    #1 d = int'(rdata);
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  function automatic int ctlv(bit dis, bit im, bit mm, bit rs, bit wn, bit pl);
    return int'(dis) | (int'(im) << 1) | (int'(mm) << 3) | (int'(rs) << 4) |
           (int'(wn) << 5) | (int'(pl) << 6);
  endfunction

  function automatic bit ew(int k, int d, int p, int m, bit pl, bit mm);
    int c = (k / d) % (p + 1);
    bit r = mm ? (c < m) : 1'b1;
    return pl ? r : !r;
  endfunction

  initial begin
    int v_rd;
    int dv[3];
    int cv[3];
    bit pl[3], mmv[3];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 wave", wave, 0);
    check("R1 irq", irq, 0);
    rd('h0C, v_rd); check("R1 ctl", v_rd, 'h61);
    rd('h04, v_rd); check("R1 clk", v_rd, 0);
    rd('h20, v_rd); check("R1 cnt", v_rd, 0);

    // R11 / R13 register placement and readback
    wr('h04, 'h3F);
    wr('h08, 32'hFFFF_FFFF);
    wr('h28, 'h1234);
    wr('h24, 'h0042);
    rd('h04, v_rd); check("R13 clk src", v_rd, 'h3F);
    rd('h08, v_rd); check("R13 clk mask", v_rd, 'h3F);
    rd('h00, v_rd); check("R11 neighbour clk", v_rd, 0);
    rd('h28, v_rd); check("R11 ival ch1", v_rd, 'h1234);
    rd('h24, v_rd); check("R11 ival ch0", v_rd, 'h42);
    rd('hFC, v_rd); check("R13 unmapped", v_rd, 0);
    wr('h64, 5);
    rd('h64, v_rd); check("R11 ien ch1", v_rd, 5);
    wr('h64, 0);
    wr('h58, 7);
    rd('h58, v_rd); check("R8 status write ignored", v_rd, 0);

    // R2 R3 R4 R12 sweep on all channels
    for (int v = 0; v < 2; v++) begin
      for (int p = 1; p <= 6; p++) begin
        for (int m = 0; m <= p + 1; m++) begin
          dv[0] = 1; dv[1] = 2; dv[2] = v ? 16 : 4;
          cv[0] = 0; cv[1] = 1; cv[2] = v ? 7 : 3;
          for (int c = 0; c < 3; c++) begin
            pl[c]  = ((c + v) % 2) == 0;
            mmv[c] = !(v == 1 && c == 1);
            wr('h00 + 4*c, cv[c]);
            wr('h24 + 4*c, p);
            wr('h30 + 4*c, m);
          end
          for (int c = 0; c < 3; c++) wr('h0C + 4*c, ctlv(0, 1, mmv[c], 1, 0, pl[c]));
          for (int n = 0; n < 2*dv[2]*(p+1) + 2; n++) begin
            @(negedge clk);
            for (int c = 0; c < 3; c++)
              check((v == 1 && c == 2) ? "R3" : !mmv[c] ? "R12" : pl[c] ? "R2" : "R4",
                    wave[c], ew(n + 2 - c, dv[c], p, m, pl[c], mmv[c]));
            @(posedge clk);
          end
        end
      end
    end
    for (int c = 0; c < 3; c++) wr('h0C + 4*c, 'h61);
    for (int c = 0; c < 3; c++) rd('h54 + 4*c, v_rd);

    // R5 waveform enable off, counter still runs
    wr('h00, 0); wr('h24, 3); wr('h30, 2);
    wr('h0C, ctlv(0, 1, 1, 1, 1, 1));
    for (int n = 0; n < 7; n++) begin
      @(negedge clk); check("R5 wave off", wave[0], 0);
      @(posedge clk);
    end
    rd('h18, v_rd); check("R5 counter runs", v_rd, 3);
    rd('h0C, v_rd); check("R7 restart bit reads 0", v_rd, 'h6A);
    wr('h0C, ctlv(0, 1, 1, 1, 1, 1));
    rd('h18, v_rd); check("R7 restart zero", v_rd, 0);

    // R6 freeze and resume
    wr('h24, 7); wr('h30, 6);
    wr('h0C, ctlv(0, 1, 1, 1, 0, 1));
    repeat (3) @(posedge clk);
    wr('h0C, ctlv(1, 1, 1, 0, 0, 1));
    @(negedge clk); check("R6 inactive", wave[0], 0);
    repeat (5) @(posedge clk);
    rd('h18, v_rd); check("R6 frozen", v_rd, 4);
    wr('h0C, ctlv(0, 1, 1, 0, 0, 1));
    rd('h18, v_rd); check("R6 resume", v_rd, 4);
    rd('h18, v_rd); check("R6 resume step", v_rd, 5);
    wr('h0C, 'h61);
    rd('h54, v_rd);

    // R8 interval flag, enable and clear-on-read
    wr('h60, 0); wr('h24, 3);
    wr('h0C, ctlv(0, 1, 0, 1, 0, 1));
    repeat (6) @(posedge clk);
    wr('h0C, ctlv(1, 1, 0, 0, 0, 1));
    @(negedge clk); check("R8 irq masked", irq[0], 0);
    wr('h60, 1);
    @(negedge clk); check("R8 irq set", irq[0], 1);
    rd('h54, v_rd); check("R8 status", v_rd, 1);
    @(negedge clk); check("R8 irq cleared", irq[0], 0);
    rd('h54, v_rd); check("R8 status cleared", v_rd, 0);

    // R10 match flag on channel 1
    rd('h58, v_rd);
    wr('h04, 0); wr('h28, 5); wr('h34, 2);
    wr('h10, ctlv(0, 1, 1, 1, 0, 1));
    rd('h58, v_rd); check("R10 no flag k0", v_rd, 0);
    rd('h58, v_rd); check("R10 no flag k1", v_rd, 0);
    wr('h10, ctlv(1, 1, 1, 0, 0, 1));
    rd('h58, v_rd); check("R10 match flag", v_rd, 2);

    // R9 free-running full wrap on channel 2
    wr('h08, 0);
    rd('h5C, v_rd);
    wr('h14, ctlv(0, 0, 0, 1, 0, 1));
    repeat (65535) @(posedge clk);
    rd('h20, v_rd); check("R9 max count", v_rd, 'hFFFF);
    rd('h20, v_rd); check("R9 wrapped", v_rd, 0);
    rd('h5C, v_rd); check("R9 overflow flag", v_rd, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule